// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Pin Expander

This block is an I2C target that gives a host a bank of 8 or 16 general-purpose pins. It holds one register the host can write and one the host can read. It has no direction register and no command or pointer byte. Each written bit sets an output latch. A latch bit of one leaves its pin weakly pulled high, so an external device can pull the pin low and the pin works as an input. A latch bit of zero turns on the pin's pull-down. A read returns the live, synchronized pin levels, not the latch.

The block runs entirely in the system clock domain. SCL and SDA are oversampled through a two-flop synchronizer, and the bus state machine acts on the edges it detects there. An active-low change flag compares the synchronized pins against a reference word. It goes low whenever the two differ. When the host finishes reading a full word, the reference is reloaded with the value the host received, so a read clears the flag once the pins are steady. The 7-bit address is a four-bit base, chosen by a parameter as 0x20 or 0x38, followed by three select inputs. In the 16-pin build every word takes two bytes on the bus, low half first.

Top module: `qbx_expander`

## Requirements
- R1: After reset every latch bit is one, so `pull_dn_o` is all zero. `irq_n_o` is high and `sda_oe_o` is low.
- R2: The target acknowledges an address byte whose upper seven bits equal {base, `addr_sel_i`}. The base is 4'b0100 when ALT_BASE=0 and 4'b0111 when ALT_BASE=1. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R3: On a non-matching address the target returns NACK. It never drives SDA and does not change its latch until the next START.
- R4: A write data byte is taken MSB first and lands in the latch at the acknowledge of that byte. A latch bit of 0 sets the matching `pull_dn_o` bit to 1, and a latch bit of 1 clears it. In the 8-pin build every data byte replaces the whole latch.
- R5: In the 16-pin build, write data bytes alternate between latch bits 7:0 and 15:8, starting with bits 7:0 after the address. Further bytes in the same transaction keep alternating, and each half updates at its own acknowledge.
- R6: A read returns the synchronized pin levels captured at the address acknowledge, MSB first, pins 7:0 first. A pin pulled low by its own latch reads 0.
- R7: `irq_n_o` goes low when the synchronized pin word differs from the reference word. It returns high if the pins come back to the reference.
- R8: On the acknowledge clock of the last byte of a read word, the reference word is reloaded with the word returned. After that, `irq_n_o` is high if the pins still match that word.
- R9: `sda_oe_o` changes only while SCL is low. After a STOP it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| addr_sel_i | input | 3 | Low three bits of the target address |
| pin_i | input | PIN_W | Levels seen on the pins |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| pull_dn_o | output | PIN_W | Pull-down enable per pin (inverse of latch) |
| irq_n_o | output | 1 | Active-low pin-change flag |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except for START and STOP. They also assume that no STOP or START is issued while the target is driving an acknowledge or a data bit, and that every SCL phase lasts well over the three-cycle synchronizer and edge-detect latency. The bench controller holds each SCL quarter period for eight system clocks and sets SDA only in the middle of SCL low. It ends a read with NACK before STOP, which keeps every transfer inside those bounds. Pin levels in the bench are changed only while the bus is idle and are held for many cycles, so the sampled word is never ambiguous.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_AACK,
        BS_WDAT,
        BS_WACK,
        BS_RDAT,
        BS_RACK,
        BS_SKIP
    } bus_st_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/qbx_i2c_tgt.sv
module qbx_i2c_tgt
    import qbx_pkg::*;
#(
    parameter int         PIN_W   = 16,
    parameter logic [3:0] ADDR_HI = 4'b0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [2:0]       addr_sel_i,
    input  logic [PIN_W-1:0] pins_s,
    output logic             sda_oe_o,
    output logic [PIN_W-1:0] latch_o,
    output logic             rd_done_o,
    output logic [PIN_W-1:0] rd_word_o,
    output bus_st_e          st_o
);
    localparam int NBYTES = PIN_W / 8;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

    typedef struct packed {
        bus_st_e          st;
        logic             scl_p;
        logic             sda_p;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic             rw;
        logic             oe;
        logic             mack;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [PIN_W-1:0] latch;
        logic [PIN_W-1:0] snap;
        logic [7:0]       rsh;
    } tgt_t;

    tgt_t q, d;
    logic scl_rise, scl_fall, bus_start, bus_stop, hit;
    logic [IDX_W-1:0] nidx;
    logic [7:0] nbyte;

    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign bus_start = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign bus_stop  = scl_s & q.scl_p & ~q.sda_p & sda_s;
    assign hit       = (q.sh[7:1] == {ADDR_HI, addr_sel_i});
    assign nidx      = (q.idx == LAST) ? '0 : q.idx + 1'b1;
    assign nbyte     = (nidx == '0) ? pins_s[7:0] : q.snap[int'(nidx)*8 +: 8];

    always_comb begin
        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
        d.done  = 1'b0;
        if (bus_start) begin
            d.st  = BS_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (bus_stop) begin
            d.st = BS_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                BS_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (hit) begin
                            d.oe  = 1'b1;
                            d.rw  = q.sh[0];
                            d.idx = '0;
                            d.st  = BS_AACK;
                            if (q.sh[0]) d.snap = pins_s;
                        end else begin
                            d.st = BS_SKIP;
                        end
                    end
                end
                BS_AACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.rsh = q.snap[7:0];
                            d.oe  = ~q.snap[7];
                            d.st  = BS_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = BS_WDAT;
                        end
                    end
                end
                BS_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.latch[int'(q.idx)*8 +: 8] = q.sh;
                        d.idx = nidx;
                        d.st  = BS_WACK;
                    end
                end
                BS_WACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = BS_WDAT;
                    end
                end
                BS_RDAT: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.cnt = '0;
                            d.oe  = 1'b0;
                            d.st  = BS_RACK;
                        end else begin
                            d.rsh = {q.rsh[6:0], 1'b0};
                            d.oe  = ~q.rsh[6];
                        end
                    end
                end
                BS_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                        d.done = (q.idx == LAST);
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.idx = nidx;
                            if (nidx == '0) d.snap = pins_s;
                            d.rsh = nbyte;
                            d.oe  = ~nbyte[7];
                            d.cnt = '0;
                            d.st  = BS_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = BS_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
            q.latch <= '1;
            q.snap  <= '1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign latch_o   = q.latch;
    assign rd_done_o = q.done;
    assign rd_word_o = q.snap;
    assign st_o      = q.st;
endmodule

// File: rtl/qbx_chg_det.sv
module qbx_chg_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic         rd_done_i,
    input  logic [W-1:0] rd_word_i,
    output logic         irq_n_o
);
    typedef struct packed {
        logic [W-1:0] ref_w;
        logic         irq_n;
    } chg_t;

    chg_t q, d;

    always_comb begin
        d       = q;
        d.ref_w = rd_done_i ? rd_word_i : q.ref_w;
        d.irq_n = (pins_s == d.ref_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ref_w <= '1;
            q.irq_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign irq_n_o = q.irq_n;
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander
    import qbx_pkg::*;
#(
    parameter int   PIN_W    = 16,
    parameter logic ALT_BASE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [2:0]       addr_sel_i,
    input  logic [PIN_W-1:0] pin_i,
    output logic             sda_oe_o,
    output logic [PIN_W-1:0] pull_dn_o,
    output logic             irq_n_o
);
    localparam logic [3:0] ADDR_HI = ALT_BASE ? 4'b0111 : 4'b0100;

    logic [1:0]       bus_s;
    logic [PIN_W-1:0] pin_s, latch, rd_word;
    logic             rd_done;
    bus_st_e          tgt_st;

    qbx_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
    );

    qbx_sync #(.W(PIN_W), .RST_VAL({PIN_W{1'b1}})) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
    );

    qbx_i2c_tgt #(.PIN_W(PIN_W), .ADDR_HI(ADDR_HI)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .addr_sel_i(addr_sel_i), .pins_s(pin_s),
        .sda_oe_o(sda_oe_o), .latch_o(latch),
        .rd_done_o(rd_done), .rd_word_o(rd_word), .st_o(tgt_st)
    );

    qbx_chg_det #(.W(PIN_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .pins_s(pin_s),
        .rd_done_i(rd_done), .rd_word_i(rd_word), .irq_n_o(irq_n_o)
    );

    assign pull_dn_o = ~latch;
endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk
    import qbx_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_s,
    input logic         sda_oe,
    input logic [W-1:0] pull_dn,
    input logic         irq_n,
    input logic [W-1:0] pins_s,
    input logic         rd_done,
    input bus_st_e      st
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pull_dn == '0 && irq_n && !sda_oe));

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R4
    latch_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_dn) |-> st == BS_WACK);

    // R3
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == BS_SKIP |-> !sda_oe);

    // R7
    irq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && $stable(pins_s) && !rd_done) |=> irq_n);
endmodule

bind qbx_expander qbx_expander_chk #(.W(PIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_oe(sda_oe_o),
    .pull_dn(pull_dn_o), .irq_n(irq_n_o), .pins_s(pin_s),
    .rd_done(rd_done), .st(tgt_st)
);

// File: tb/qbx_expander_tb.sv
module qbx_expander_tb;
    localparam int Q = 8;
    localparam logic [2:0] SEL16 = 3'b101;
    localparam logic [2:0] SEL8  = 3'b010;
    localparam logic [6:0] A16 = {4'b0100, SEL16};
    localparam logic [6:0] A8  = {4'b0111, SEL8};
    // {write word, external level}
    localparam logic [31:0] VEC [0:5] = '{
        32'hFFFF_FFFF, 32'h00FF_FFFF, 32'hA55A_FFFF,
        32'hFFFF_0F0F, 32'hF0F0_3C3C, 32'h1234_FFF0
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic oe16, oe8, irq16, irq8, sda_bus;
    logic [15:0] ext16 = 16'hFFFF, pd16, pins16;
    logic [7:0]  ext8 = 8'hFF, pd8, pins8;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~oe16 & ~oe8;
    assign pins16  = ext16 & ~pd16;
    assign pins8   = ext8 & ~pd8;

    qbx_expander #(.PIN_W(16), .ALT_BASE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .addr_sel_i(SEL16), .pin_i(pins16), .sda_oe_o(oe16),
        .pull_dn_o(pd16), .irq_n_o(irq16)
    );

    qbx_expander #(.PIN_W(8), .ALT_BASE(1'b1)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .addr_sel_i(SEL8), .pin_i(pins8), .sda_oe_o(oe8),
        .pull_dn_o(pd8), .irq_n_o(irq8)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bstart();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic tx(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = ~sda_bus;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic rx(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = ~mack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic wr16(input logic [15:0] w);
        logic a;
        bstart(); tx({A16, 1'b0}, a); chk("R2 ack16", 16'(a), 16'h1);
        tx(w[7:0], a); tx(w[15:8], a); bstop();
    endtask

    task automatic rd16(output logic [15:0] w);
        logic a;
        bstart(); tx({A16, 1'b1}, a);
        rx(1'b1, w[7:0]); rx(1'b0, w[15:8]); bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic a, a2;
        logic [7:0]  b;
        logic [15:0] w;
        wq(5); rst_n = 1'b1; wq(5);

        // R1 reset state
        chk("R1 pd16", pd16, 16'h0);
        chk("R1 pd8", 16'(pd8), 16'h0);
        chk("R1 irq/oe", {14'h0, irq16 & irq8, oe16 | oe8}, 16'h2);

        // R3 wrong address: nack, data ignored
        bstart(); tx({7'h27, 1'b0}, a); tx(8'h00, a2); bstop();
        chk("R3 nack addr", 16'(a), 16'h0);
        chk("R3 nack data", 16'(a2), 16'h0);
        chk("R3 latch kept", pd16, 16'h0);
        chk("R3 latch8 kept", 16'(pd8), 16'h0);

        // R2 R4 R6 8-pin build on alternate base
        bstart(); tx({A8, 1'b0}, a); tx(8'hC3, a2); bstop();
        chk("R2 ack alt base", 16'(a), 16'h1);
        chk("R4 pd8", 16'(pd8), 16'h003C);
        chk("R2 other target untouched", pd16, 16'h0);
        bstart(); tx({A8, 1'b1}, a); rx(1'b0, b); bstop();
        chk("R6 read8 pin levels", 16'(b), 16'h00C3);
        chk("R9 released after stop", {14'h0, oe16 | oe8, sda_bus}, 16'h1);

        // R4 R5 per-byte update and alternation
        bstart(); tx({A16, 1'b0}, a); tx(8'h11, a);
        chk("R4 low half at ack", pd16, 16'h00EE);
        tx(8'h22, a);
        chk("R5 high half", pd16, 16'hDDEE);
        tx(8'h33, a);
        chk("R5 third byte to low", pd16, 16'hDDCC);
        tx(8'h44, a); bstop();
        chk("R5 fourth byte to high", pd16, 16'hBBCC);

        // R7 R8 change flag
        wr16(16'hFFFF); rd16(w);
        chk("R8 cleared by read", 16'(irq16), 16'h1);
        ext16 = 16'hFFF7; wq(10);
        chk("R7 change flags", 16'(irq16), 16'h0);
        ext16 = 16'hFFFF; wq(10);
        chk("R7 return clears", 16'(irq16), 16'h1);
        ext16 = 16'hFFF7; wq(10);
        chk("R7 change again", 16'(irq16), 16'h0);
        rd16(w);
        chk("R6 read external low", w, 16'hFFF7);
        chk("R8 read clears", 16'(irq16), 16'h1);
        ext16 = 16'hFFFF; wq(10);
        chk("R7 differs from new reference", 16'(irq16), 16'h0);
        rd16(w);
        chk("R8 read clears again", 16'(irq16), 16'h1);

        // vector table: R5 write, R6 read-back, R8 flag after read
        for (int k = 0; k < 6; k++) begin
            ext16 = VEC[k][15:0];
            wr16(VEC[k][31:16]);
            chk("R5 vec latch", pd16, ~VEC[k][31:16]);
            rd16(w);
            chk("R6 vec read", w, VEC[k][31:16] & VEC[k][15:0]);
            wq(4);
            chk("R8 vec flag", 16'(irq16), 16'h1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule